// File: doc/BRIEF.md
# Dual-Clock First-Word-Fall-Through FIFO with Quantized Fill Levels

This block moves data words from a producer clock domain to a consumer clock domain whose clocks have no fixed relation. The producer offers a word with a put strobe and sees a full flag. The consumer sees the oldest stored word and a valid flag without asking for it first. After taking the word it pulses got, and the next word is then presented.

Words are kept in a two-port RAM array. The array is written on the producer clock and read through a registered port on the consumer clock. A small read-side state machine keeps the output register loaded. Its states are `RD_IDLE` (no word presented) and `RD_SHOW` (a word is presented). `RD_IDLE -> RD_SHOW` happens when the array holds an unread word. `RD_SHOW -> RD_SHOW` happens on a got while another word is waiting, and that word is fetched in the same cycle. `RD_SHOW -> RD_IDLE` happens on a got when nothing else is waiting.

Pointers are one bit wider than the array address. They cross between the domains in Gray code through two-flop synchronizers. Each domain derives a coarse level from its own pointer and the synchronized copy of the other one. On the consumer side the level reports stored words, and on the producer side it reports free space. Either level can be removed by giving it zero bits.

Top module: `xclk_fwft_fifo`

## Requirements
- R1: Each pointer is handed to the other domain in Gray code and changes in at most one bit per clock of its own domain.
- R2: When `rd_valid` is 1, `rd_data` holds the oldest word not yet taken. Without a got, `rd_valid` and `rd_data` stay unchanged.
- R3: A got while `rd_valid` is 1 removes the presented word. A got while `rd_valid` is 0 has no effect.
- R4: The FIFO holds up to 2^ADDR_W words in the array plus one presented word. `wr_full` is 1 once that many are stored. A put while `wr_full` is 1 is ignored and stores nothing.
- R5: Words leave in the order they were accepted, under any put and got pattern and any ratio of the two clocks.
- R6: The value of `rd_fill_lvl` is the held count divided by 2^(ADDR_W-FILL_BITS), rounded down and saturated at 2^FILL_BITS-1. The held count includes the presented word. The value times 2^(ADDR_W-FILL_BITS) never exceeds the words actually held.
- R7: The value of `wr_free_lvl` is the free array slots divided by 2^(ADDR_W-FREE_BITS), rounded down and saturated at 2^FREE_BITS-1. The value times 2^(ADDR_W-FREE_BITS) never exceeds 2^ADDR_W+1 minus the words held, and it is 0 while `wr_full` is 1.
- R8: Each side has a synchronous active-high reset, and the two may overlap. After both have been released, `rd_valid`=0, `wr_full`=0, `rd_fill_lvl`=0 and `wr_free_lvl` is at its maximum.
- R9: A level whose bits parameter is 0 is removed, and its 1-bit output stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Producer clock |
| wr_rst | input | 1 | Producer synchronous reset, active high |
| wr_put | input | 1 | Offer `wr_data` for storage |
| wr_data | input | DATA_W | Word to store |
| wr_full | output | 1 | No further word can be accepted |
| wr_free_lvl | output | max(FREE_BITS,1) | Quantized guaranteed free space |
| rd_clk | input | 1 | Consumer clock |
| rd_rst | input | 1 | Consumer synchronous reset, active high |
| rd_got | input | 1 | Presented word has been taken |
| rd_data | output | DATA_W | Presented (oldest) word |
| rd_valid | output | 1 | `rd_data` holds a word |
| rd_fill_lvl | output | max(FILL_BITS,1) | Quantized guaranteed stored words |

## Verification
The bench uses DATA_W=8 and ADDR_W=4, so a depth of 16, and 2-bit levels. One level step is then four words, and saturation occurs when the FIFO is completely full or completely empty. Both are reached within a few dozen puts. A second instance built with both bits parameters at 0 runs on the same stimulus to show that the levels are removed. Unrelated clock periods of 20 ns and 26 ns drift the pointer crossings through every phase relation. Random put and got rates in both directions drive the FIFO to full and to empty many times.

// File: rtl/xclk_fifo_pkg.sv
package xclk_fifo_pkg;

    // Read-side presentation state
    typedef enum logic {
        RD_IDLE = 1'b0,   // output register holds no word
        RD_SHOW = 1'b1    // output register holds the oldest word
    } rd_state_e;

endpackage

// File: rtl/xclk_level.sv
// Quantizes a count into BITS bits: floor(cnt / 2^(ADDR_W-BITS)), saturated.
module xclk_level #(
    parameter int CNT_W  = 6,
    parameter int ADDR_W = 4,
    parameter int BITS   = 2
) (
    input  logic [CNT_W-1:0] cnt,
    output logic [BITS-1:0]  lvl
);
    localparam int SHIFT = ADDR_W - BITS;
    localparam logic [CNT_W-1:0] MAXV = CNT_W'((1 << BITS) - 1);

    logic [CNT_W-1:0] scaled;

    always_comb begin
        scaled = cnt >> SHIFT;
        lvl    = (scaled > MAXV) ? {BITS{1'b1}} : scaled[BITS-1:0];
    end
endmodule

// File: rtl/xclk_ram.sv
// Two-port storage: write on producer clock, registered read on consumer clock.
module xclk_ram #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rclk,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    always_ff @(posedge rclk) begin
        if (re) begin
            rdata <= mem[raddr];
        end
    end
endmodule

// File: rtl/xclk_wr_ctrl.sv
// Producer side: write pointer, Gray export, read-pointer sync, full, free level.
module xclk_wr_ctrl #(
    parameter int ADDR_W    = 4,
    parameter int FREE_BITS = 2,
    parameter int LVL_W     = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              put,
    input  logic [ADDR_W:0]   rgray_in,
    output logic              full,
    output logic              we,
    output logic [ADDR_W-1:0] waddr,
    output logic [ADDR_W:0]   wgray,
    output logic [LVL_W-1:0]  free_lvl
);
    localparam int PW = ADDR_W + 1;
    localparam logic [PW-1:0] DEPTH_V = {1'b1, {ADDR_W{1'b0}}};

    logic [PW-1:0] wbin, wnext, rsync1, rsync2, rbin, used;
    logic          accept;

    always_comb begin
        rbin[PW-1] = rsync2[PW-1];
        for (int i = PW - 2; i >= 0; i--) begin
            rbin[i] = rbin[i+1] ^ rsync2[i];
        end
        used   = wbin - rbin;
        full   = used[ADDR_W];
        accept = put && !full;
        wnext  = wbin + PW'(1);
        we     = accept;
        waddr  = wbin[ADDR_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wbin   <= '0;
            wgray  <= '0;
            rsync1 <= '0;
            rsync2 <= '0;
        end else begin
            rsync1 <= rgray_in;
            rsync2 <= rsync1;
            if (accept) begin
                wbin  <= wnext;
                wgray <= wnext ^ (wnext >> 1);
            end
        end
    end

    generate
        if (FREE_BITS > 0) begin : g_lvl
            xclk_level #(.CNT_W(PW), .ADDR_W(ADDR_W), .BITS(FREE_BITS)) u_lvl (
                .cnt (DEPTH_V - used),
                .lvl (free_lvl)
            );
        end else begin : g_nolvl
            assign free_lvl = '0;
        end
    endgenerate
endmodule

// File: rtl/xclk_rd_ctrl.sv
// Consumer side: presentation FSM, read pointer, write-pointer sync, fill level.
module xclk_rd_ctrl
    import xclk_fifo_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int FILL_BITS = 2,
    parameter int LVL_W     = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              got,
    input  logic [ADDR_W:0]   wgray_in,
    output logic              re,
    output logic [ADDR_W-1:0] raddr,
    output logic [ADDR_W:0]   rgray,
    output logic              valid,
    output logic [LVL_W-1:0]  fill_lvl
);
    localparam int PW = ADDR_W + 1;

    rd_state_e     state, state_n;
    logic [PW-1:0] rbin, rnext, wsync1, wsync2, wbin;
    logic [PW-1:0] pending;
    logic [PW:0]   held;
    logic          avail, fetch;

    always_comb begin
        wbin[PW-1] = wsync2[PW-1];
        for (int i = PW - 2; i >= 0; i--) begin
            wbin[i] = wbin[i+1] ^ wsync2[i];
        end
        pending = wbin - rbin;
        avail   = (pending != '0);
        rnext   = rbin + PW'(1);
    end

    // Next-state and fetch decision
    always_comb begin
        state_n = state;
        fetch   = 1'b0;
        unique case (state)
            RD_IDLE: begin
                if (avail) begin
                    fetch   = 1'b1;
                    state_n = RD_SHOW;
                end
            end
            RD_SHOW: begin
                if (got) begin
                    if (avail) begin
                        fetch = 1'b1;
                    end else begin
                        state_n = RD_IDLE;
                    end
                end
            end
        endcase
    end

    // State register and pointers
    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= RD_IDLE;
            rbin   <= '0;
            rgray  <= '0;
            wsync1 <= '0;
            wsync2 <= '0;
        end else begin
            state  <= state_n;
            wsync1 <= wgray_in;
            wsync2 <= wsync1;
            if (fetch) begin
                rbin  <= rnext;
                rgray <= rnext ^ (rnext >> 1);
            end
        end
    end

    // Outputs
    always_comb begin
        valid = (state == RD_SHOW);
        re    = fetch;
        raddr = rbin[ADDR_W-1:0];
        held  = {1'b0, pending} + {{PW{1'b0}}, valid};
    end

    generate
        if (FILL_BITS > 0) begin : g_lvl
            xclk_level #(.CNT_W(PW + 1), .ADDR_W(ADDR_W), .BITS(FILL_BITS)) u_lvl (
                .cnt (held),
                .lvl (fill_lvl)
            );
        end else begin : g_nolvl
            assign fill_lvl = '0;
        end
    endgenerate
endmodule

// File: rtl/xclk_fwft_fifo.sv
module xclk_fwft_fifo #(
    parameter int DATA_W    = 8,
    parameter int ADDR_W    = 4,
    parameter int FILL_BITS = 2,
    parameter int FREE_BITS = 2,
    localparam int FILL_W   = (FILL_BITS > 0) ? FILL_BITS : 1,
    localparam int FREE_W   = (FREE_BITS > 0) ? FREE_BITS : 1
) (
    input  logic              wr_clk,
    input  logic              wr_rst,
    input  logic              wr_put,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_full,
    output logic [FREE_W-1:0] wr_free_lvl,
    input  logic              rd_clk,
    input  logic              rd_rst,
    input  logic              rd_got,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic [FILL_W-1:0] rd_fill_lvl
);
    logic              ram_we, ram_re;
    logic [ADDR_W-1:0] ram_waddr, ram_raddr;
    logic [ADDR_W:0]   wr_gray, rd_gray;

    xclk_wr_ctrl #(.ADDR_W(ADDR_W), .FREE_BITS(FREE_BITS), .LVL_W(FREE_W)) u_wr (
        .clk      (wr_clk),
        .rst      (wr_rst),
        .put      (wr_put),
        .rgray_in (rd_gray),
        .full     (wr_full),
        .we       (ram_we),
        .waddr    (ram_waddr),
        .wgray    (wr_gray),
        .free_lvl (wr_free_lvl)
    );

    xclk_rd_ctrl #(.ADDR_W(ADDR_W), .FILL_BITS(FILL_BITS), .LVL_W(FILL_W)) u_rd (
        .clk      (rd_clk),
        .rst      (rd_rst),
        .got      (rd_got),
        .wgray_in (wr_gray),
        .re       (ram_re),
        .raddr    (ram_raddr),
        .rgray    (rd_gray),
        .valid    (rd_valid),
        .fill_lvl (rd_fill_lvl)
    );

    xclk_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
        .wclk  (wr_clk),
        .we    (ram_we),
        .waddr (ram_waddr),
        .wdata (wr_data),
        .rclk  (rd_clk),
        .re    (ram_re),
        .raddr (ram_raddr),
        .rdata (rd_data)
    );
endmodule

// File: rtl/xclk_fwft_fifo_chk.sv
module xclk_fwft_fifo_chk #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4,
    parameter int FREE_W = 2
) (
    input logic              wr_clk,
    input logic              wr_rst,
    input logic              wr_full,
    input logic [FREE_W-1:0] wr_free_lvl,
    input logic              rd_clk,
    input logic              rd_rst,
    input logic              rd_got,
    input logic              rd_valid,
    input logic [DATA_W-1:0] rd_data,
    input logic [ADDR_W:0]   wr_gray,
    input logic [ADDR_W:0]   rd_gray
);
    a_r1_wr_gray_step: assert property (@(posedge wr_clk) disable iff (wr_rst)
        $countones(wr_gray ^ $past(wr_gray)) <= 1);

    a_r1_rd_gray_step: assert property (@(posedge rd_clk) disable iff (rd_rst)
        $countones(rd_gray ^ $past(rd_gray)) <= 1);

    a_r2_hold_word: assert property (@(posedge rd_clk) disable iff (rd_rst)
        (rd_valid && !rd_got) |=> (rd_valid && $stable(rd_data)));

    a_r4_full_blocks: assert property (@(posedge wr_clk) disable iff (wr_rst)
        wr_full |=> $stable(wr_gray));

    a_r7_full_no_space: assert property (@(posedge wr_clk) disable iff (wr_rst)
        wr_full |-> (wr_free_lvl == '0));
endmodule

bind xclk_fwft_fifo xclk_fwft_fifo_chk #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .FREE_W (FREE_W)
) u_chk (
    .wr_clk      (wr_clk),
    .wr_rst      (wr_rst),
    .wr_full     (wr_full),
    .wr_free_lvl (wr_free_lvl),
    .rd_clk      (rd_clk),
    .rd_rst      (rd_rst),
    .rd_got      (rd_got),
    .rd_valid    (rd_valid),
    .rd_data     (rd_data),
    .wr_gray     (wr_gray),
    .rd_gray     (rd_gray)
);

// File: tb/xclk_fwft_fifo_bench.sv
module xclk_fwft_fifo_bench;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 4;
    localparam int LB     = 2;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int QSTEP  = DEPTH >> LB;
    localparam int LMAX   = (1 << LB) - 1;

    logic              wr_clk = 0, rd_clk = 0;
    logic              wr_rst = 1, rd_rst = 1;
    logic              wr_put = 0, rd_got = 0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              wr_full, rd_valid;
    logic [LB-1:0]     wr_free_lvl, rd_fill_lvl;
    logic [DATA_W-1:0] rd_data;
    logic              z_full, z_valid;
    logic [0:0]        z_free, z_fill;
    logic [DATA_W-1:0] z_data;

    always #10ns wr_clk = ~wr_clk;
    always #13ns rd_clk = ~rd_clk;

    xclk_fwft_fifo #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .FILL_BITS(LB), .FREE_BITS(LB)) u_xclk_fwft_fifo (
        .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_put(wr_put), .wr_data(wr_data),
        .wr_full(wr_full), .wr_free_lvl(wr_free_lvl),
        .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_got(rd_got), .rd_data(rd_data),
        .rd_valid(rd_valid), .rd_fill_lvl(rd_fill_lvl)
    );

    // Same stimulus, levels removed (R9)
    xclk_fwft_fifo #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .FILL_BITS(0), .FREE_BITS(0)) u_xclk_fwft_fifo_nolvl (
        .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_put(wr_put), .wr_data(wr_data),
        .wr_full(z_full), .wr_free_lvl(z_free),
        .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_got(rd_got), .rd_data(z_data),
        .rd_valid(z_valid), .rd_fill_lvl(z_fill)
    );

    int n_cmp = 0, n_bad = 0;
    int acc = 0, gots = 0, seq = 0;
    bit done = 0;
    logic [DATA_W-1:0] sb [$];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    task automatic chk_free();
        int stored = acc - gots;
        chk(int'(wr_free_lvl) * QSTEP <= DEPTH + 1 - stored, "R7 free bound",
            int'(wr_free_lvl) * QSTEP, DEPTH + 1 - stored);
        chk(z_free == 1'b0, "R9 free removed", int'(z_free), 0);
    endtask

    task automatic chk_fill();
        int stored = acc - gots;
        chk(int'(rd_fill_lvl) * QSTEP <= stored, "R6 fill bound",
            int'(rd_fill_lvl) * QSTEP, stored);
        chk(z_fill == 1'b0, "R9 fill removed", int'(z_fill), 0);
    endtask

    // Driver: offers words, pushes accepted ones to the scoreboard
    task automatic put_words(input int n, input int pct);
        int cnt = 0;
        while (cnt < n) begin
            @(negedge wr_clk);
            chk_free();
            if ($urandom_range(99) < pct) begin
                wr_put  = 1;
                wr_data = DATA_W'(seq);
                if (!wr_full) begin
                    sb.push_back(DATA_W'(seq));
                    seq++;
                    acc++;
                    cnt++;
                end
            end else begin
                wr_put = 0;
            end
        end
        @(negedge wr_clk);
        wr_put = 0;
    endtask

    // Monitor: compares presented words and pops them
    task automatic take_words(input int n, input int pct);
        int cnt = 0;
        while (cnt < n) begin
            @(negedge rd_clk);
            chk_fill();
            if ($urandom_range(99) < pct) begin
                rd_got = 1;
                if (rd_valid) begin
                    if (sb.size() == 0) begin
                        chk(0, "R5 unexpected word", int'(rd_data), -1);
                    end else begin
                        chk(rd_data == sb[0], "R5 order", int'(rd_data), int'(sb[0]));
                        void'(sb.pop_front());
                    end
                    gots++;
                    cnt++;
                end
            end else begin
                rd_got = 0;
            end
        end
        @(negedge rd_clk);
        rd_got = 0;
    endtask

    // Overlapping resets: producer first, consumer later; released in the same order
    task automatic do_reset();
        @(negedge wr_clk);
        wr_put = 0;
        wr_rst = 1;
        repeat (2) @(negedge rd_clk);
        rd_got = 0;
        rd_rst = 1;
        repeat (3) @(negedge wr_clk);
        wr_rst = 0;
        repeat (2) @(negedge rd_clk);
        rd_rst = 0;
        sb.delete();
        acc  = 0;
        gots = 0;
        repeat (4) @(negedge rd_clk);
        chk(rd_valid == 0, "R8 valid after reset", int'(rd_valid), 0);
        chk(rd_fill_lvl == 0, "R8 fill after reset", int'(rd_fill_lvl), 0);
        @(negedge wr_clk);
        chk(wr_full == 0, "R8 full after reset", int'(wr_full), 0);
        chk(wr_free_lvl == LB'(LMAX), "R8 free after reset", int'(wr_free_lvl), LMAX);
    endtask

    initial begin
        repeat (150000) @(posedge wr_clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            report();
        end
    end

    initial begin
        do_reset();

        // Fill to capacity with no consumer activity (R4, R6, R7)
        put_words(DEPTH + 1, 100);
        chk(acc == DEPTH + 1, "R4 capacity", acc, DEPTH + 1);
        repeat (3) begin
            @(negedge wr_clk);
            chk(wr_full == 1, "R4 full held", int'(wr_full), 1);
            wr_put  = 1;
            wr_data = 8'hEE;
        end
        @(negedge wr_clk);
        wr_put = 0;
        repeat (10) @(negedge rd_clk);
        chk(rd_fill_lvl == LB'(LMAX), "R6 fill saturated", int'(rd_fill_lvl), LMAX);
        chk(rd_valid == 1, "R2 word presented", int'(rd_valid), 1);
        chk(rd_data == sb[0], "R2 oldest word", int'(rd_data), int'(sb[0]));
        @(negedge wr_clk);
        chk(wr_free_lvl == 0, "R7 no free space", int'(wr_free_lvl), 0);

        // Drain; ignored put must not surface (R4, R5)
        take_words(DEPTH + 1, 50);
        repeat (10) @(negedge rd_clk);
        chk(rd_valid == 0, "R4 ignored put absent", int'(rd_valid), 0);
        chk(rd_fill_lvl == 0, "R6 fill empty", int'(rd_fill_lvl), 0);
        @(negedge wr_clk);
        chk(wr_free_lvl == LB'(LMAX), "R7 free max", int'(wr_free_lvl), LMAX);

        // got while empty is ignored (R3)
        repeat (6) begin
            @(negedge rd_clk);
            rd_got = 1;
            chk(rd_valid == 0, "R3 empty got", int'(rd_valid), 0);
        end
        @(negedge rd_clk);
        rd_got = 0;
        put_words(1, 100);
        repeat (8) @(negedge rd_clk);
        chk(rd_valid == 1, "R3 word after empty got", int'(rd_valid), 1);
        chk(rd_data == sb[0], "R3 word intact", int'(rd_data), int'(sb[0]));
        take_words(1, 100);

        // Random traffic, both rate orderings (R5, R6, R7)
        fork
            put_words(3000, 60);
            take_words(3000, 55);
        join
        fork
            put_words(2000, 30);
            take_words(2000, 90);
        join
        fork
            put_words(1500, 95);
            take_words(1500, 25);
        join

        // Reset with data held, then resume (R8)
        put_words(5, 100);
        repeat (10) @(negedge rd_clk);
        do_reset();
        fork
            put_words(40, 70);
            take_words(40, 70);
        join
        repeat (10) @(negedge rd_clk);
        chk(rd_valid == 0, "R5 all drained", int'(rd_valid), 0);

        report();
    end
endmodule